// File: doc/BRIEF.md
# Sequential Signed Divider, 32-bit by 16-bit, with Condition Flags

This unit divides a signed two-word dividend by a signed one-word divisor and returns a one-word quotient, a one-word remainder and four condition flags: negative, zero, overflow and carry. It is meant to sit beside the arithmetic unit of a 16-bit minicomputer-style datapath. The surrounding pipeline presents the high and low dividend words and the divisor together with a one-cycle `start`. It then waits for the one-cycle `done` pulse and writes the results back.

The quotient is truncated toward zero, and the remainder carries the sign of the dividend. The core works on magnitudes with a restoring shift-subtract loop of one quotient bit per cycle, and applies the signs once the loop ends. A divisor of zero is caught at `start`: it returns overflow and carry on the next cycle and runs no iterations. Any quotient outside the signed word range is reported as overflow, and -32768 counts as inside that range. While an overflow is reported the quotient and remainder carry no meaning, and the unit drives them to zero.

Top module: `div32s16_seq`

## Requirements
- R1: On a valid result the quotient equals the dividend divided by the divisor, truncated toward zero, and the remainder equals dividend minus quotient times divisor, so its sign follows the dividend (34 / -5 gives -6 rem 4).
- R2: A zero divisor, with any dividend including zero, gives flag_v=1, flag_c=1 and flag_z=0, with `done` high on the cycle after `start` is taken.
- R3: When the true quotient lies outside -32768..32767 (for example 0x7FFFFFFF / 1, 0x80000000 / -1), the unit reports flag_v=1, flag_c=0 and flag_z=0.
- R4: The end points of the range are valid results: a quotient of exactly -32768 or exactly 32767 sets no overflow and is returned exactly.
- R5: On a valid result flag_n equals bit 15 of the quotient, flag_z is 1 exactly when the quotient is zero, and flag_v=flag_c=0.
- R6: With a non-zero divisor, `done` rises exactly 17 cycles after the clock edge that takes `start`. `busy` is high from the cycle after that edge until `done`, `done` lasts one cycle, and `busy` is low while `done` is high.
- R7: A `start` raised while `busy` is high is ignored: it produces no extra `done`, and the result that follows belongs to the operands taken at the accepted `start`.
- R8: While reset is held, `busy`, `done`, the quotient, the remainder and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Takes the operands when the unit is idle |
| dvd_hi | input | 16 | Dividend, upper word (holds the sign) |
| dvd_lo | input | 16 | Dividend, lower word |
| dvsr | input | 16 | Divisor, two's complement |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse: results and flags are valid |
| quot | output | 16 | Quotient, two's complement |
| rem | output | 16 | Remainder, two's complement |
| flag_n | output | 1 | Quotient negative |
| flag_z | output | 1 | Quotient zero |
| flag_v | output | 1 | Overflow or zero divisor |
| flag_c | output | 1 | Zero divisor |

## Verification
Results come due at one of two fixed distances from the edge that takes `start`: one cycle for a zero divisor, and seventeen cycles for every other divisor, overflow included. When the driver issues a division, it stores the exact cycle in which `done` must be seen. The monitor compares only in that cycle and treats a `done` in any other cycle as a failure. A `start` raised in the middle of a busy period therefore fails the run if it produces an extra pulse. It also fails the run if it changes the pending result.

// File: rtl/div32s16_pkg.sv
`timescale 1ns/1ps
package div32s16_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } div_flags_t;
endpackage

// File: rtl/div_operand_prep.sv
`timescale 1ns/1ps
// Converts signed operands to magnitudes and flags the cases decided up front.
module div_operand_prep #(
  parameter int W = 16
) (
  input  logic [W-1:0] hi_word,
  input  logic [W-1:0] lo_word,
  input  logic [W-1:0] dv_word,
  output logic         sgn_dd,
  output logic         sgn_dv,
  output logic [W-1:0] ddm_hi,
  output logic [W-1:0] ddm_lo,
  output logic [W-1:0] dv_mag,
  output logic         dv_zero,
  output logic         pre_ovf
);
  localparam int DW = 2 * W;

  logic [DW-1:0] dd_raw;
  logic [DW-1:0] dd_mag;

  always_comb begin
    dd_raw  = {hi_word, lo_word};
    sgn_dd  = dd_raw[DW-1];
    sgn_dv  = dv_word[W-1];
    dd_mag  = sgn_dd ? (~dd_raw + 1'b1) : dd_raw;
    dv_mag  = sgn_dv ? (~dv_word + 1'b1) : dv_word;
    ddm_hi  = dd_mag[DW-1:W];
    ddm_lo  = dd_mag[W-1:0];
    dv_zero = (dv_word == '0);
    // quotient magnitude would need more than W bits
    pre_ovf = (ddm_hi >= dv_mag);
  end
endmodule

// File: rtl/div_iter_step.sv
`timescale 1ns/1ps
// One restoring shift-subtract step on magnitudes.
module div_iter_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] part_rem,
  input  logic [W-1:0] q_in,
  input  logic [W-1:0] dv_mag,
  output logic [W-1:0] rem_out,
  output logic [W-1:0] q_out
);
  logic [W:0] trial;
  logic       fits;

  always_comb begin
    trial   = {part_rem, q_in[W-1]};
    fits    = (trial >= {1'b0, dv_mag});
    rem_out = fits ? (trial[W-1:0] - dv_mag) : trial[W-1:0];
    q_out   = {q_in[W-2:0], fits};
  end
endmodule

// File: rtl/div_sign_fix.sv
`timescale 1ns/1ps
// Applies operand signs, checks the quotient range and forms the flags.
module div_sign_fix
  import div32s16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] qmag,
  input  logic [W-1:0] rmag,
  input  logic         sgn_dd,
  input  logic         sgn_dv,
  input  logic         pre_ovf,
  output logic [W-1:0] q_res,
  output logic [W-1:0] r_res,
  output div_flags_t   flags
);
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};

  logic         neg_q;
  logic         ovf;
  logic [W-1:0] q_s;
  logic [W-1:0] r_s;

  always_comb begin
    neg_q = sgn_dd ^ sgn_dv;
    ovf   = pre_ovf | (neg_q ? (qmag > NEG_LIM) : (qmag > POS_LIM));
    q_s   = neg_q ? (~qmag + 1'b1) : qmag;
    r_s   = sgn_dd ? (~rmag + 1'b1) : rmag;
    if (ovf) begin
      q_res = '0;
      r_res = '0;
      flags = '{n: 1'b0, z: 1'b0, v: 1'b1, c: 1'b0};
    end else begin
      q_res = q_s;
      r_res = r_s;
      flags = '{n: q_s[W-1], z: (q_s == '0), v: 1'b0, c: 1'b0};
    end
  end
endmodule

// File: rtl/div32s16_seq.sv
`timescale 1ns/1ps
module div32s16_seq
  import div32s16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dvd_hi,
  input  logic [W-1:0] dvd_lo,
  input  logic [W-1:0] dvsr,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_v,
  output logic         flag_c
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

  div_state_e   state_q;
  logic [CW-1:0] step_q;
  logic [W-1:0] rem_acc_q;
  logic [W-1:0] quo_sh_q;
  logic [W-1:0] dvm_q;
  logic         sdd_q, sdv_q, povf_q;
  logic         done_q;
  logic [W-1:0] quot_q, rem_q;
  div_flags_t   flags_q;

  logic         p_sdd, p_sdv, p_zero, p_ovf;
  logic [W-1:0] p_hi, p_lo, p_dvm;
  logic [W-1:0] s_rem, s_q;
  logic [W-1:0] f_q, f_r;
  div_flags_t   f_flags;

  div_operand_prep #(.W(W)) u_prep (
    .hi_word (dvd_hi),
    .lo_word (dvd_lo),
    .dv_word (dvsr),
    .sgn_dd  (p_sdd),
    .sgn_dv  (p_sdv),
    .ddm_hi  (p_hi),
    .ddm_lo  (p_lo),
    .dv_mag  (p_dvm),
    .dv_zero (p_zero),
    .pre_ovf (p_ovf)
  );

  div_iter_step #(.W(W)) u_step (
    .part_rem (rem_acc_q),
    .q_in     (quo_sh_q),
    .dv_mag   (dvm_q),
    .rem_out  (s_rem),
    .q_out    (s_q)
  );

  div_sign_fix #(.W(W)) u_fix (
    .qmag    (quo_sh_q),
    .rmag    (rem_acc_q),
    .sgn_dd  (sdd_q),
    .sgn_dv  (sdv_q),
    .pre_ovf (povf_q),
    .q_res   (f_q),
    .r_res   (f_r),
    .flags   (f_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      step_q    <= '0;
      rem_acc_q <= '0;
      quo_sh_q  <= '0;
      dvm_q     <= '0;
      sdd_q     <= 1'b0;
      sdv_q     <= 1'b0;
      povf_q    <= 1'b0;
      done_q    <= 1'b0;
      quot_q    <= '0;
      rem_q     <= '0;
      flags_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (p_zero) begin
              done_q  <= 1'b1;
              quot_q  <= '0;
              rem_q   <= '0;
              flags_q <= '{n: 1'b0, z: 1'b0, v: 1'b1, c: 1'b1};
            end else begin
              rem_acc_q <= p_hi;
              quo_sh_q  <= p_lo;
              dvm_q     <= p_dvm;
              sdd_q     <= p_sdd;
              sdv_q     <= p_sdv;
              povf_q    <= p_ovf;
              step_q    <= '0;
              state_q   <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          rem_acc_q <= s_rem;
          quo_sh_q  <= s_q;
          step_q    <= step_q + 1'b1;
          if (step_q == LAST_STEP) state_q <= ST_FIN;
        end
        ST_FIN: begin
          quot_q  <= f_q;
          rem_q   <= f_r;
          flags_q <= f_flags;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign done   = done_q;
  assign quot   = quot_q;
  assign rem    = rem_q;
  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_v = flags_q.v;
  assign flag_c = flags_q.c;
endmodule

// File: rtl/div32s16_chk.sv
`timescale 1ns/1ps
module div32s16_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [W-1:0] dvsr,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quot,
  input logic         flag_n,
  input logic         flag_z,
  input logic         flag_v,
  input logic         flag_c
);
  // R2: zero divisor answers on the next cycle with V and C set
  a_r2_zero_next: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && dvsr == '0) |=> (done && flag_v && flag_c));

  // R2: carry appears only together with overflow
  a_r2_c_with_v: assert property (@(posedge clk) disable iff (rst)
    (done && flag_c) |-> flag_v);

  // R3: any overflow report keeps Z low
  a_r3_ovf_no_z: assert property (@(posedge clk) disable iff (rst)
    (done && flag_v) |-> !flag_z);

  // R5: valid result flags follow the quotient
  a_r5_valid_flags: assert property (@(posedge clk) disable iff (rst)
    (done && !flag_v) |-> (!flag_c && (flag_z == (quot == '0)) && (flag_n == quot[W-1])));

  // R6: unit is idle while the result is presented
  a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R6: busy is entered only through an accepted start
  a_r6_busy_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

bind div32s16_seq div32s16_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .dvsr   (dvsr),
  .busy   (busy),
  .done   (done),
  .quot   (quot),
  .flag_n (flag_n),
  .flag_z (flag_z),
  .flag_v (flag_v),
  .flag_c (flag_c)
);

// File: tb/test_div32s16_seq.sv
`timescale 1ns/1ps
module test_div32s16_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] dvd_hi = '0, dvd_lo = '0, dvsr = '0;
  logic        busy, done, flag_n, flag_z, flag_v, flag_c;
  logic [15:0] quot, rem;

  div32s16_seq #(.W(16)) i_div32s16_seq (
    .clk(clk), .rst(rst), .start(start),
    .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvsr(dvsr),
    .busy(busy), .done(done), .quot(quot), .rem(rem),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int          due;
    bit          zero;
    bit          ovf;
    logic [15:0] q;
    logic [15:0] r;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   ended = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  // driver: waits for an empty scoreboard, issues one division
  task automatic issue(input logic [31:0] dd, input logic [15:0] dv, input string tag);
    exp_t   e;
    longint sD, sd, qq, rr;
    do begin
      @(negedge clk); #1;
    end while (sb.size() != 0);
    sD = longint'($signed(dd));
    sd = longint'($signed(dv));
    e.tag  = tag;
    e.zero = (sd == 0);
    e.ovf  = 1'b0;
    e.q    = '0;
    e.r    = '0;
    if (sd != 0) begin
      qq = sD / sd;
      rr = sD % sd;
      e.ovf = (qq > 32767) || (qq < -32768);
      e.q   = qq[15:0];
      e.r   = rr[15:0];
    end
    e.due = cyc + (e.zero ? 1 : 18);
    {dvd_hi, dvd_lo} = dd;
    dvsr  = dv;
    start = 1'b1;
    sb.push_back(e);
    @(negedge clk); #1;
    start = 1'b0;
    if (!e.zero) check(busy === 1'b1, "R6", "busy after start", longint'(busy), 1);
  endtask

  // monitor: compares in the due cycle only
  exp_t h;
  always @(negedge clk) begin
    if (!rst) begin
      if (sb.size() != 0 && cyc == sb[0].due) begin
        h = sb.pop_front();
        check(done === 1'b1, "R6", {"done at due cycle ", h.tag}, longint'(done), 1);
        if (h.zero) begin
          check({flag_v, flag_c, flag_z} === 3'b110, "R2", {"zero divide flags ", h.tag},
                longint'({flag_v, flag_c, flag_z}), 3'b110);
        end else if (h.ovf) begin
          check({flag_v, flag_c, flag_z} === 3'b100, "R3", {"overflow flags ", h.tag},
                longint'({flag_v, flag_c, flag_z}), 3'b100);
        end else begin
          check(quot === h.q, "R1/R4", {"quotient ", h.tag}, longint'(quot), longint'(h.q));
          check(rem === h.r, "R1", {"remainder ", h.tag}, longint'(rem), longint'(h.r));
          check({flag_n, flag_z, flag_v, flag_c} === {h.q[15], h.q == 16'd0, 2'b00}, "R5",
                {"valid flags ", h.tag}, longint'({flag_n, flag_z, flag_v, flag_c}),
                longint'({h.q[15], h.q == 16'd0, 2'b00}));
        end
        check(!(done && busy), "R6", "busy low with done", longint'(busy), 0);
      end else if (done === 1'b1) begin
        check(1'b0, "R7", "done outside any due cycle", 1, 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R6", "watchdog expired", 1, 0);
    wrap_up();
  end

  initial begin
    logic [31:0] rd;
    logic [15:0] rv;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    check({busy, done} === 2'b00, "R8", "busy/done in reset", longint'({busy, done}), 0);
    check({quot, rem} === 32'd0, "R8", "results in reset", longint'({quot, rem}), 0);
    check({flag_n, flag_z, flag_v, flag_c} === 4'd0, "R8", "flags in reset",
          longint'({flag_n, flag_z, flag_v, flag_c}), 0);
    #1 rst = 1'b0;

    // R1: four sign quadrants
    issue(32'sd34,  16'sd5,  "R1 34/5");
    issue(32'sd34,  -16'sd5, "R1 34/-5");
    issue(-32'sd34, 16'sd5,  "R1 -34/5");
    issue(-32'sd34, -16'sd5, "R1 -34/-5");
    issue(32'sd0,   16'sd7,  "R5 zero quotient");
    issue(32'sd3,   -16'sd4, "R5 small over large");
    // R2: zero divisor
    issue(32'd0,          16'd0, "R2 0/0");
    issue(32'd1,          16'd0, "R2 1/0");
    issue(32'hFFFF_FFFF,  16'd0, "R2 -1/0");
    // R3: overflow
    issue(32'h7FFF_FFFF, 16'd1,      "R3 max/1");
    issue(32'h7FFF_FFFF, 16'hFFFE,   "R3 max/-2");
    issue(32'h8000_0000, 16'd1,      "R3 min/1");
    issue(32'h8000_0000, 16'hFFFF,   "R3 min/-1");
    issue(32'h8000_0000, 16'hFFFE,   "R3 min/-2");
    issue(-32'sd1073741824, 16'sd32767, "R3 just beyond -32768");
    // R4: range end points
    issue(-32'sd1073709057, 16'sd32767, "R4 q=-32768 r=-1");
    issue(32'sd1073741824, 16'h8000,    "R4 q=-32768 by -32768");
    issue(32'sd715827882, 16'sd21846,   "R4 q=32767");
    issue(-32'sd715849728, 16'sd21846,  "R4 q=-32768 r=0");
    issue(32'sd715871574, -16'sd21846,  "R3 q=-32769");

    // R7: start during busy is ignored
    issue(32'sd1000, 16'sd7, "R7 kept operands");
    repeat (4) @(negedge clk);
    #1 dvd_hi = 16'h7FFF; dvd_lo = 16'h1234; dvsr = 16'd3; start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
    repeat (3) @(negedge clk);
    #1 dvsr = 16'd0; start = 1'b1;
    @(negedge clk); #1 start = 1'b0;

    // R1: mixed random patterns
    for (int k = 0; k < 240; k++) begin
      rv = 16'($urandom);
      case (k % 3)
        0: rd = $urandom;
        1: rd = 32'($signed(24'($urandom)));
        default: rd = 32'(longint'($signed(16'($urandom))) * longint'($signed(rv))
                          + longint'($signed(8'($urandom))));
      endcase
      if (k % 40 == 0) rv = 16'd0;
      issue(rd, rv, "R1 random");
    end

    while (sb.size() != 0) @(negedge clk);
    repeat (25) @(negedge clk);
    wrap_up();
  end
endmodule